// File: doc/BRIEF.md
# Polyphase Edge Placement Scheduler

This block converts a stream of requested square-wave edge times into per-sample commands for an output path that is clocked by several phase-shifted copies of a single sample clock. Each request carries a fixed-point time in sub-sample units. The block separates that time into a coarse sample slot and a fine phase index. It then produces, for every sample, the output level and the phase position to use. The commands are worked out two samples before they are needed, so the only crossing into the skewed-phase clocks happens after the final register.

A free-running sample counter supplies the time base. An accepted edge stays pending until the look-ahead stage reaches its slot. At that point the level toggles and the phase begins to move toward the requested position. The phase can move by at most a configurable number of positions per sample, so the selected clock never runs effectively too fast. A request that arrives too late to be scheduled is dropped and reported.

With the default widths the fine grid has 16 positions per sample. At 1 GS/s one position is 62.5 ps.

Top module: `edge_phase_sched`

## Requirements
- R1: After reset, `cur_slot` reads 0 and then increases by one every clock, wrapping modulo 2^SLOT_W.
- R2: In `req_time`, the upper SLOT_W bits give the slot and the lower PHASE_W bits give the phase. For an accepted edge that is not late, `out_level` toggles in exactly the cycle where `cur_slot` equals the slot.
- R3: When no edge reaches its slot, `out_level` keeps its value. `out_phase` changes only while it is still moving toward the most recent target phase.
- R4: Each sample, the phase moves toward its target along the shorter way around the 2^PHASE_W circle, by at most `step_max` positions. A distance of exactly half the circle is taken in the increasing direction. The target is updated in the sample of the edge, and that sample already takes the first step.
- R5: `limit_flag` is set when an edge is applied whose circular distance from the current phase exceeds `step_max`. It stays set until reset.
- R6: `req_ready` is high when no edge is pending. After an edge is accepted that is not late, `req_ready` stays low until the cycle where `cur_slot` equals the slot minus 1.
- R7: Let d = (slot − `cur_slot`) mod 2^SLOT_W, taken in the accepting cycle. If d ≤ 2 or d ≥ 2^(SLOT_W−1), the request is late. A late request is dropped without affecting level or phase, and it sets `late_flag`, which stays set until reset.
- R8: While `rst` is high, and in the first cycle after it falls, `out_level` is 0, `out_phase` is 0, both flags are clear and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Edge request valid |
| req_ready | output | 1 | Block can accept an edge request |
| req_time | input | SLOT_W+PHASE_W | Edge time: slot in the upper bits, phase in the lower bits |
| step_max | input | PHASE_W | Maximum phase movement per sample |
| cur_slot | output | SLOT_W | Sample counter for the sample the outputs apply to |
| out_level | output | 1 | Square-wave level for this sample |
| out_phase | output | PHASE_W | Phase position selected for this sample |
| late_flag | output | 1 | Sticky: a request arrived too late and was dropped |
| limit_flag | output | 1 | Sticky: a phase jump was spread over several samples |

## Verification
The assertions assume that `step_max` stays below half the phase circle. Under that assumption, two consecutive output phases are always less than 180 degrees apart. The stimulus draws `step_max` only from 1 to 7 and applies `req_valid` for a single cycle, only once `req_ready` is high. Slot offsets are picked around the look-ahead boundary, past it, behind the counter and across counter wrap. The bench's reference model therefore sees every ordering the requirements describe.

// File: rtl/eps_pkg.sv
package eps_pkg;
  // samples between command computation and use
  localparam int unsigned LOOKAHEAD = 2;
endpackage

// File: rtl/eps_sample_counter.sv
module eps_sample_counter #(
  parameter int unsigned SLOT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SLOT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/eps_req_stage.sv
module eps_req_stage
  import eps_pkg::*;
#(
  parameter int unsigned SLOT_W  = 8,
  parameter int unsigned PHASE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [SLOT_W+PHASE_W-1:0] req_time,
  input  logic [SLOT_W-1:0]         cnt,
  output logic                      req_ready,
  output logic                      fire,
  output logic [PHASE_W-1:0]        pend_phase,
  output logic                      late_flag
);
  localparam logic [SLOT_W-1:0] AHEAD = SLOT_W'(LOOKAHEAD);

  logic              pend_q;
  logic [SLOT_W-1:0] pend_slot_q;
  logic [SLOT_W-1:0] req_slot, req_dist, pend_dist;
  logic              accept, req_late;

  assign req_slot  = req_time[SLOT_W+PHASE_W-1:PHASE_W];
  assign req_dist  = req_slot - cnt;
  assign pend_dist = pend_slot_q - cnt;
  // too close to be computed ahead, or in the past half of the counter range
  assign req_late  = (req_dist <= AHEAD) || req_dist[SLOT_W-1];
  assign req_ready = !pend_q;
  assign accept    = req_valid && req_ready;
  assign fire      = pend_q && (pend_dist == AHEAD);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_slot_q <= '0;
      pend_phase  <= '0;
      late_flag   <= 1'b0;
    end else begin
      if (fire) pend_q <= 1'b0;
      if (accept) begin
        if (req_late) begin
          late_flag <= 1'b1;
        end else begin
          pend_q      <= 1'b1;
          pend_slot_q <= req_slot;
          pend_phase  <= req_time[PHASE_W-1:0];
        end
      end
    end
  end
endmodule

// File: rtl/eps_phase_limiter.sv
module eps_phase_limiter #(
  parameter int unsigned PHASE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               fire,
  input  logic [PHASE_W-1:0] pend_phase,
  input  logic [PHASE_W-1:0] step_max,
  output logic               s1_level,
  output logic [PHASE_W-1:0] s1_phase,
  output logic               limit_flag
);
  localparam logic [PHASE_W-1:0] HALF = PHASE_W'(2 ** (PHASE_W - 1));

  logic [PHASE_W-1:0] tgt_q, goal, diff, mag, move, nxt;
  logic               fwd;

  always_comb begin
    goal = fire ? pend_phase : tgt_q;
    diff = goal - s1_phase;
    fwd  = (diff <= HALF);
    mag  = fwd ? diff : (~diff + 1'b1);
    move = (mag > step_max) ? step_max : mag;
    nxt  = fwd ? (s1_phase + move) : (s1_phase - move);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_level   <= 1'b0;
      s1_phase   <= '0;
      tgt_q      <= '0;
      limit_flag <= 1'b0;
    end else begin
      s1_phase <= nxt;
      if (fire) begin
        s1_level <= ~s1_level;
        tgt_q    <= pend_phase;
        if (mag > step_max) limit_flag <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/edge_phase_sched.sv
module edge_phase_sched #(
  parameter int unsigned SLOT_W  = 8,
  parameter int unsigned PHASE_W = 4
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  output logic                      req_ready,
  input  logic [SLOT_W+PHASE_W-1:0] req_time,
  input  logic [PHASE_W-1:0]        step_max,
  output logic [SLOT_W-1:0]         cur_slot,
  output logic                      out_level,
  output logic [PHASE_W-1:0]        out_phase,
  output logic                      late_flag,
  output logic                      limit_flag
);
  logic               fire, s1_level;
  logic [PHASE_W-1:0] pend_phase, s1_phase;

  eps_sample_counter #(.SLOT_W(SLOT_W)) u_cnt (
    .clk(clk), .rst(rst), .cnt(cur_slot)
  );

  eps_req_stage #(.SLOT_W(SLOT_W), .PHASE_W(PHASE_W)) u_req (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_time(req_time),
    .cnt(cur_slot), .req_ready(req_ready), .fire(fire),
    .pend_phase(pend_phase), .late_flag(late_flag)
  );

  eps_phase_limiter #(.PHASE_W(PHASE_W)) u_lim (
    .clk(clk), .rst(rst), .fire(fire), .pend_phase(pend_phase),
    .step_max(step_max), .s1_level(s1_level), .s1_phase(s1_phase),
    .limit_flag(limit_flag)
  );

  // final stage: last register before the skewed-phase domains
  always_ff @(posedge clk) begin
    if (rst) begin
      out_level <= 1'b0;
      out_phase <= '0;
    end else begin
      out_level <= s1_level;
      out_phase <= s1_phase;
    end
  end
endmodule

// File: rtl/eps_chk.sv
module eps_chk #(
  parameter int unsigned SLOT_W  = 8,
  parameter int unsigned PHASE_W = 4
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      req_valid,
  input logic                      req_ready,
  input logic [SLOT_W+PHASE_W-1:0] req_time,
  input logic [SLOT_W-1:0]         cur_slot,
  input logic [PHASE_W-1:0]        out_phase,
  input logic                      late_flag,
  input logic                      limit_flag
);
  localparam int unsigned NPH = 2 ** PHASE_W;

  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  function automatic int unsigned circ_dist(logic [PHASE_W-1:0] a, logic [PHASE_W-1:0] b);
    logic [PHASE_W-1:0] d;
    d = a - b;
    return (int'(d) <= NPH / 2) ? int'(d) : NPH - int'(d);
  endfunction

  function automatic logic too_late(logic [SLOT_W+PHASE_W-1:0] t, logic [SLOT_W-1:0] c);
    logic [SLOT_W-1:0] d;
    d = t[SLOT_W+PHASE_W-1:PHASE_W] - c;
    return (d <= SLOT_W'(2)) || d[SLOT_W-1];
  endfunction

  // R1
  slot_advance_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> cur_slot == SLOT_W'($past(cur_slot) + 1'b1));

  // R4
  phase_halfturn_chk: assert property (@(posedge clk) disable iff (rst)
    seen |-> circ_dist(out_phase, $past(out_phase)) < NPH / 2);

  // R5
  limit_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    limit_flag |=> limit_flag);

  // R7
  late_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    late_flag |=> late_flag);

  // R7
  late_raise_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && too_late(req_time, cur_slot)) |=> late_flag);

  // R6
  ready_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !too_late(req_time, cur_slot)) |=> !req_ready);
endmodule

bind edge_phase_sched eps_chk #(.SLOT_W(SLOT_W), .PHASE_W(PHASE_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .req_time(req_time), .cur_slot(cur_slot), .out_phase(out_phase),
  .late_flag(late_flag), .limit_flag(limit_flag)
);

// File: tb/edge_phase_sched_tb.sv
module edge_phase_sched_tb;
  localparam int SW = 8;
  localparam int PW = 4;
  localparam int S  = 2 ** SW;
  localparam int N  = 2 ** PW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [SW+PW-1:0] req_time = '0;
  logic [PW-1:0] step_max = PW'(4);
  logic req_ready, out_level, late_flag, limit_flag;
  logic [SW-1:0] cur_slot;
  logic [PW-1:0] out_phase;

  always #2.5 clk = ~clk;

  edge_phase_sched #(.SLOT_W(SW), .PHASE_W(PW)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_time(req_time), .step_max(step_max), .cur_slot(cur_slot),
    .out_level(out_level), .out_phase(out_phase), .late_flag(late_flag),
    .limit_flag(limit_flag)
  );

  int total = 0, bad = 0, cyc = 0;
  bit done = 0;

  // reference model state
  int m_cnt, m_pslot, m_pph, m_s1lvl, m_s1ph, m_tgt, m_lvl, m_ph, m_late, m_lim;
  bit m_pend;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_pend = 0; m_pslot = 0; m_pph = 0; m_s1lvl = 0; m_s1ph = 0;
      m_tgt = 0; m_lvl = 0; m_ph = 0; m_late = 0; m_lim = 0;
    end else begin
      bit rdy, fire, fwd;
      int goal, diff, mag, mv, nph, stp, slot, d;
      rdy  = !m_pend;
      fire = m_pend && ((((m_pslot - m_cnt) % S) + S) % S == 2);
      stp  = int'(step_max);
      goal = fire ? m_pph : m_tgt;
      diff = (((goal - m_s1ph) % N) + N) % N;
      fwd  = diff <= N / 2;
      mag  = fwd ? diff : N - diff;
      mv   = (mag > stp) ? stp : mag;
      nph  = fwd ? (m_s1ph + mv) % N : (m_s1ph - mv + N) % N;
      m_lvl = m_s1lvl;
      m_ph  = m_s1ph;
      if (fire) begin
        m_s1lvl = 1 - m_s1lvl;
        m_tgt = m_pph;
        if (mag > stp) m_lim = 1;
        m_pend = 0;
      end
      m_s1ph = nph;
      if (req_valid && rdy) begin
        slot = int'(req_time >> PW);
        d = (((slot - m_cnt) % S) + S) % S;
        if (d <= 2 || d >= S / 2) m_late = 1;
        else begin m_pend = 1; m_pslot = slot; m_pph = int'(req_time[PW-1:0]); end
      end
      m_cnt = (m_cnt + 1) % S;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk("R1 cur_slot", int'(cur_slot), m_cnt);
      chk("R2 R3 out_level", int'(out_level), m_lvl);
      chk("R4 out_phase", int'(out_phase), m_ph);
      chk("R6 req_ready", int'(req_ready), int'(!m_pend));
      chk("R7 late_flag", int'(late_flag), m_late);
      chk("R5 limit_flag", int'(limit_flag), m_lim);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // one-cycle request at slot cur_slot+off once ready
  task automatic send(int off, int ph);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_time = {SW'((int'(cur_slot) + off) % S), PW'(ph)};
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state while rst is held
    chk("R8 level", int'(out_level), 0);
    chk("R8 phase", int'(out_phase), 0);
    chk("R8 flags", int'(late_flag) + int'(limit_flag), 0);
    chk("R8 ready", int'(req_ready), 1);
    rst = 1'b0;
    @(negedge clk);
    chk("R8 slot after release", int'(cur_slot), 1);
    // R2 R4: edges within the step limit
    send(5, 3);  idle(8);
    send(6, 6);  idle(8);
    send(3, 6);  idle(6);   // R6 minimal look-ahead distance
    // R7: late requests at and behind the look-ahead point
    send(2, 9);  idle(4);
    send(0, 9);  idle(4);
    send(200, 9); idle(4);
    // R5: half-circle jump, taken upward and spread
    send(10, 14); idle(8);
    step_max = PW'(7);
    send(12, 1);  idle(10);
    step_max = PW'(2);
    send(4, 9);   idle(12);
    // R1 R3: idle across counter wrap
    idle(300);
    // mixed patterns
    for (int i = 0; i < 60; i++) begin
      step_max = PW'(1 + ($urandom % 7));
      send(($urandom % 45), $urandom % N);
      idle($urandom % 6);
    end
    idle(60);
    finish_run();
  end
endmodule